// File: doc/BRIEF.md
# Banked Cache Request Scheduler

This block is the per-cycle dispatch stage in front of a banked cache. Each cycle it looks at three kinds of work for every bank and picks at most one pipeline request per bank. The three kinds are a replay popped from the bank's miss-status queue, a fill response returning from memory, and new requests arriving on N core input ports. Replays always win. A fill is taken only when the bank has no replay. Core requests get whatever banks remain idle after that.

The core address is split into a word offset, a bank index, a set index and a tag. Core inputs are scanned in ascending index order. The first request to reach an idle bank opens a core slot in that bank. Later requests to the same line (same set, tag and direction) join that slot through a per-port lane, chosen as the input index modulo the lane count. A request that cannot be placed is not acknowledged and stays at its input. When the bank's miss-status queue is full, a request that would need an entry is held and counted as a stall.

Core inputs use valid/ready. `core_ready[i]` is driven in the same cycle from that cycle's inputs, and it is high only for a request that was accepted or merged. A source must hold its request stable until it sees ready. Fill inputs use valid/ready with `fill_ready = !replay_valid`. Replay inputs are always taken. The chosen bank requests appear on registered outputs one cycle after the handshake.

Top module: `cache_req_sched`

## Requirements
- R1: With the default parameters (8-bit address, 1 offset bit, 1 bank bit, 2 set bits), address bit 0 is the word offset, bit 1 selects the bank, bits 3:2 are the set and bits 7:4 are the tag. The set and tag of a core slot are reported on `bq_set` and `bq_tag`.
- R2: A field of zero width extracts as 0. With BANK_W = 0 every core request goes to bank 0, whatever the address.
- R3: A bank with `replay_valid` high takes the replay that cycle (kind code 1). `replay_ready` is always 1.
- R4: A bank with no replay and with `fill_valid` high takes the fill (kind code 2). `fill_ready` equals the inverse of that bank's `replay_valid`.
- R5: A core request to a bank that holds a replay or a fill this cycle is skipped. Its `core_ready` stays low.
- R6: A core request uses lane (input index mod LANES). It merges into the bank's core slot only if its set, tag and write flag all match the slot and its lane is still free. Otherwise it is skipped.
- R7: When the bank's `mshr_full` is high, a core request is stalled unless it is a write while `wt_mode` is 1. `stall_cnt` grows by one for each stalled request each cycle and wraps.
- R8: Inputs are scanned from index 0 upward, so the lowest-index placeable request opens a new slot. `core_ready[i]` is high only when request i was accepted or merged.
- R9: During reset every bank output is idle (kind 0, valid 0, no lanes) and `stall_cnt` is 0.
- R10: Bank requests appear on the outputs the cycle after the handshake. A core slot has kind code 3, and each of its lanes carries the input index and the core tag. Replay and fill slots carry zero set, tag, write and lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 = write-through, so writes need no miss entry |
| core_valid | input | N_IN | Core request present, per input |
| core_ready | output | N_IN | Core request accepted or merged this cycle |
| core_addr | input | N_IN x ADDR_W | Core word address |
| core_write | input | N_IN | Core request is a write |
| core_tag | input | N_IN x CTAG_W | Core request tag, returned in the lane |
| replay_valid | input | NB | Miss-status queue has a replay ready |
| replay_ready | output | NB | Replay popped (always 1) |
| fill_valid | input | NB | Memory fill response waiting |
| fill_ready | output | NB | Fill taken this cycle |
| mshr_full | input | NB | Bank miss-status queue is full |
| bq_valid | output | NB | Bank request valid |
| bq_kind | output | NB x 2 | 0 idle, 1 replay, 2 fill, 3 core |
| bq_set | output | NB x SET_IW | Set index of core slot |
| bq_tag | output | NB x TAG_W | Line tag of core slot |
| bq_write | output | NB | Core slot is a write |
| bq_lane_valid | output | NB x LANES | Lane occupied |
| bq_lane_id | output | NB x LANES x ID_W | Input index in lane |
| bq_lane_tag | output | NB x LANES x CTAG_W | Core tag in lane |
| stall_cnt | output | STALL_W | Running count of stalled core requests |

## Verification
Directed patterns come first. Two inputs hit the same line on different lanes, which must merge. Two inputs hit the same line on the same lane, which must not. Same-bank requests with a different set, and with a different write flag, show that merging depends on the whole line and on the direction. A replay and a fill on the same bank, with core traffic aimed at both banks, separates the service order from plain bank occupancy. The miss-queue-full cases cover a read, a write-through write and a write-back write, which isolates the stall exemption. After that, random traffic confined to two tags, with random replay, fill and full flags, is compared every cycle against a queue-free reference model. A second instance with no bank bits checks that the bank field extracts as zero.

// File: rtl/cache_sched_pkg.sv
package cache_sched_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_REPLAY = 2'd1,
    SLOT_FILL   = 2'd2,
    SLOT_CORE   = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 1,
  parameter int BANK_W = 1,
  parameter int SET_W  = 2,
  localparam int TAG_W   = ADDR_W - OFF_W - BANK_W - SET_W,
  localparam int BANK_IW = (BANK_W > 0) ? BANK_W : 1,
  localparam int SET_IW  = (SET_W > 0) ? SET_W : 1,
  localparam int TAG_IW  = (TAG_W > 0) ? TAG_W : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [BANK_IW-1:0] bank,
  output logic [SET_IW-1:0]  set_idx,
  output logic [TAG_IW-1:0]  line_tag
);
  generate
    if (OFF_W > 0) begin : g_off
      logic unused_off;
      assign unused_off = ^addr[OFF_W-1:0];
    end
    if (BANK_W > 0) begin : g_bank
      assign bank = addr[OFF_W +: BANK_W];
    end else begin : g_nobank
      assign bank = '0;
    end
    if (SET_W > 0) begin : g_set
      assign set_idx = addr[OFF_W+BANK_W +: SET_W];
    end else begin : g_noset
      assign set_idx = '0;
    end
    if (TAG_W > 0) begin : g_tag
      assign line_tag = addr[ADDR_W-1 -: TAG_W];
    end else begin : g_notag
      assign line_tag = '0;
    end
  endgenerate
endmodule

// File: rtl/cache_bank_arb.sv
module cache_bank_arb
  import cache_sched_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int NB      = 2,
  parameter int LANES   = 2,
  parameter int CTAG_W  = 3,
  parameter int BANK_IW = 1,
  parameter int SET_IW  = 2,
  parameter int TAG_IW  = 4,
  localparam int ID_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CNT_W  = $clog2(N_IN + 1)
) (
  input  logic                               wt_mode,
  input  logic [N_IN-1:0]                    core_valid,
  input  logic [N_IN-1:0]                    core_write,
  input  logic [N_IN-1:0][CTAG_W-1:0]        core_tag,
  input  logic [N_IN-1:0][BANK_IW-1:0]       core_bank,
  input  logic [N_IN-1:0][SET_IW-1:0]        core_set,
  input  logic [N_IN-1:0][TAG_IW-1:0]        core_ltag,
  input  logic [NB-1:0]                      replay_valid,
  input  logic [NB-1:0]                      fill_valid,
  input  logic [NB-1:0]                      mshr_full,
  output slot_kind_e [NB-1:0]                nx_kind,
  output logic [NB-1:0][SET_IW-1:0]          nx_set,
  output logic [NB-1:0][TAG_IW-1:0]          nx_tag,
  output logic [NB-1:0]                      nx_write,
  output logic [NB-1:0][LANES-1:0]           nx_lv,
  output logic [NB-1:0][LANES-1:0][ID_W-1:0] nx_lid,
  output logic [NB-1:0][LANES-1:0][CTAG_W-1:0] nx_ltag,
  output logic [N_IN-1:0]                    core_ready,
  output logic [CNT_W-1:0]                   stall_inc
);
  always_comb begin
    logic [BANK_IW-1:0] b;
    logic needs_entry;
    logic same_line;
    nx_set     = '0;
    nx_tag     = '0;
    nx_write   = '0;
    nx_lv      = '0;
    nx_lid     = '0;
    nx_ltag    = '0;
    core_ready = '0;
    stall_inc  = '0;
    b          = '0;
    for (int k = 0; k < NB; k++) begin
      if (replay_valid[k])    nx_kind[k] = SLOT_REPLAY;
      else if (fill_valid[k]) nx_kind[k] = SLOT_FILL;
      else                    nx_kind[k] = SLOT_IDLE;
    end
    for (int i = 0; i < N_IN; i++) begin
      b           = core_bank[i];
      needs_entry = !(core_write[i] && wt_mode);
      same_line   = (nx_set[b] == core_set[i]) && (nx_tag[b] == core_ltag[i])
                    && (nx_write[b] == core_write[i]);
      if (core_valid[i] && nx_kind[b] != SLOT_REPLAY && nx_kind[b] != SLOT_FILL) begin
        if (needs_entry && mshr_full[b]) begin
          stall_inc = stall_inc + CNT_W'(1);
        end else if (nx_kind[b] == SLOT_CORE) begin
          if (same_line && !nx_lv[b][i % LANES]) begin
            nx_lv[b][i % LANES]   = 1'b1;
            nx_lid[b][i % LANES]  = ID_W'(i);
            nx_ltag[b][i % LANES] = core_tag[i];
            core_ready[i]         = 1'b1;
          end
        end else begin
          nx_kind[b]            = SLOT_CORE;
          nx_set[b]             = core_set[i];
          nx_tag[b]             = core_ltag[i];
          nx_write[b]           = core_write[i];
          nx_lv[b][i % LANES]   = 1'b1;
          nx_lid[b][i % LANES]  = ID_W'(i);
          nx_ltag[b][i % LANES] = core_tag[i];
          core_ready[i]         = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cache_req_sched.sv
module cache_req_sched
  import cache_sched_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int ADDR_W  = 8,
  parameter int OFF_W   = 1,
  parameter int BANK_W  = 1,
  parameter int SET_W   = 2,
  parameter int LANES   = 2,
  parameter int CTAG_W  = 3,
  parameter int STALL_W = 8,
  localparam int NB      = 1 << BANK_W,
  localparam int TAG_W   = ADDR_W - OFF_W - BANK_W - SET_W,
  localparam int BANK_IW = (BANK_W > 0) ? BANK_W : 1,
  localparam int SET_IW  = (SET_W > 0) ? SET_W : 1,
  localparam int TAG_IW  = (TAG_W > 0) ? TAG_W : 1,
  localparam int ID_W    = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CNT_W   = $clog2(N_IN + 1)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wt_mode,
  input  logic [N_IN-1:0]                      core_valid,
  output logic [N_IN-1:0]                      core_ready,
  input  logic [N_IN-1:0][ADDR_W-1:0]          core_addr,
  input  logic [N_IN-1:0]                      core_write,
  input  logic [N_IN-1:0][CTAG_W-1:0]          core_tag,
  input  logic [NB-1:0]                        replay_valid,
  output logic [NB-1:0]                        replay_ready,
  input  logic [NB-1:0]                        fill_valid,
  output logic [NB-1:0]                        fill_ready,
  input  logic [NB-1:0]                        mshr_full,
  output logic [NB-1:0]                        bq_valid,
  output logic [NB-1:0][1:0]                   bq_kind,
  output logic [NB-1:0][SET_IW-1:0]            bq_set,
  output logic [NB-1:0][TAG_IW-1:0]            bq_tag,
  output logic [NB-1:0]                        bq_write,
  output logic [NB-1:0][LANES-1:0]             bq_lane_valid,
  output logic [NB-1:0][LANES-1:0][ID_W-1:0]   bq_lane_id,
  output logic [NB-1:0][LANES-1:0][CTAG_W-1:0] bq_lane_tag,
  output logic [STALL_W-1:0]                   stall_cnt
);
  logic [N_IN-1:0][BANK_IW-1:0] dec_bank;
  logic [N_IN-1:0][SET_IW-1:0]  dec_set;
  logic [N_IN-1:0][TAG_IW-1:0]  dec_tag;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_split
      cache_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .SET_W(SET_W)
      ) u_split (
        .addr(core_addr[i]), .bank(dec_bank[i]),
        .set_idx(dec_set[i]), .line_tag(dec_tag[i])
      );
    end
  endgenerate

  slot_kind_e [NB-1:0]                nx_kind;
  logic [NB-1:0][SET_IW-1:0]          nx_set;
  logic [NB-1:0][TAG_IW-1:0]          nx_tag;
  logic [NB-1:0]                      nx_write;
  logic [NB-1:0][LANES-1:0]           nx_lv;
  logic [NB-1:0][LANES-1:0][ID_W-1:0] nx_lid;
  logic [NB-1:0][LANES-1:0][CTAG_W-1:0] nx_ltag;
  logic [CNT_W-1:0]                   stall_inc;

  cache_bank_arb #(
    .N_IN(N_IN), .NB(NB), .LANES(LANES), .CTAG_W(CTAG_W),
    .BANK_IW(BANK_IW), .SET_IW(SET_IW), .TAG_IW(TAG_IW)
  ) u_arb (
    .wt_mode(wt_mode), .core_valid(core_valid), .core_write(core_write),
    .core_tag(core_tag), .core_bank(dec_bank), .core_set(dec_set),
    .core_ltag(dec_tag), .replay_valid(replay_valid), .fill_valid(fill_valid),
    .mshr_full(mshr_full), .nx_kind(nx_kind), .nx_set(nx_set), .nx_tag(nx_tag),
    .nx_write(nx_write), .nx_lv(nx_lv), .nx_lid(nx_lid), .nx_ltag(nx_ltag),
    .core_ready(core_ready), .stall_inc(stall_inc)
  );

  assign replay_ready = '1;
  assign fill_ready   = ~replay_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bq_kind       <= '0;
      bq_set        <= '0;
      bq_tag        <= '0;
      bq_write      <= '0;
      bq_lane_valid <= '0;
      bq_lane_id    <= '0;
      bq_lane_tag   <= '0;
      stall_cnt     <= '0;
    end else begin
      for (int k = 0; k < NB; k++) bq_kind[k] <= nx_kind[k];
      bq_set        <= nx_set;
      bq_tag        <= nx_tag;
      bq_write      <= nx_write;
      bq_lane_valid <= nx_lv;
      bq_lane_id    <= nx_lid;
      bq_lane_tag   <= nx_ltag;
      stall_cnt     <= stall_cnt + STALL_W'(stall_inc);
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_valid
    assign bq_valid[k] = (bq_kind[k] != 2'd0);
  end

  // R7
  no_stall_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|core_valid) |=> $stable(stall_cnt));
  // R8
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready & ~core_valid) == '0);

  generate
    for (genvar k = 0; k < NB; k++) begin : g_chk
      // R3
      replay_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid[k] |=> bq_kind[k] == 2'd1);
      // R4
      fill_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid[k] && !replay_valid[k]) |=> bq_kind[k] == 2'd2);
      // R5
      busy_bank_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_valid[k] || fill_valid[k]) |=> bq_kind[k] != 2'd3);
      // R6
      lanes_only_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bq_lane_valid[k] != '0) |-> bq_kind[k] == 2'd3);
    end
  endgenerate
endmodule

// File: tb/tb_cache_req_sched.sv
module tb_cache_req_sched;
  localparam int N = 4, AW = 8, LN = 2, CT = 3, NB = 2, TW = 4, SW = 2, IDW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;
  logic wt;
  logic [N-1:0] cv, crdy, cw;
  logic [N-1:0][AW-1:0] ca;
  logic [N-1:0][CT-1:0] ct;
  logic [NB-1:0] rv, rr, fv, fr, mf, bv, bw;
  logic [NB-1:0][1:0] bk;
  logic [NB-1:0][SW-1:0] bs;
  logic [NB-1:0][TW-1:0] bt;
  logic [NB-1:0][LN-1:0] blv;
  logic [NB-1:0][LN-1:0][IDW-1:0] bid;
  logic [NB-1:0][LN-1:0][CT-1:0] btg;
  logic [7:0] sc;

  cache_req_sched dut (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt), .core_valid(cv), .core_ready(crdy),
    .core_addr(ca), .core_write(cw), .core_tag(ct), .replay_valid(rv),
    .replay_ready(rr), .fill_valid(fv), .fill_ready(fr), .mshr_full(mf),
    .bq_valid(bv), .bq_kind(bk), .bq_set(bs), .bq_tag(bt), .bq_write(bw),
    .bq_lane_valid(blv), .bq_lane_id(bid), .bq_lane_tag(btg), .stall_cnt(sc)
  );

  // second instance without bank bits
  logic [N-1:0] z_cv, z_crdy;
  logic [0:0] z_rr, z_fr, z_bv, z_bw;
  logic [0:0][1:0] z_bk;
  logic [0:0][1:0] z_bs;
  logic [0:0][4:0] z_bt;
  logic [0:0][LN-1:0] z_blv;
  logic [0:0][LN-1:0][IDW-1:0] z_bid;
  logic [0:0][LN-1:0][CT-1:0] z_btg;
  logic [7:0] z_sc;

  cache_req_sched #(.BANK_W(0)) dut_nobank (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt), .core_valid(z_cv), .core_ready(z_crdy),
    .core_addr(ca), .core_write(cw), .core_tag(ct), .replay_valid(1'b0),
    .replay_ready(z_rr), .fill_valid(1'b0), .fill_ready(z_fr), .mshr_full(1'b0),
    .bq_valid(z_bv), .bq_kind(z_bk), .bq_set(z_bs), .bq_tag(z_bt), .bq_write(z_bw),
    .bq_lane_valid(z_blv), .bq_lane_id(z_bid), .bq_lane_tag(z_btg), .stall_cnt(z_sc)
  );

  int nchk = 0, nerr = 0;
  int ek[NB], es[NB], et[NB], ew[NB], er[N], efr[NB];
  int elv[NB][LN], eid[NB][LN], etg[NB][LN];
  int estall = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(int tg, int st, int bk_, int off);
    return {tg[3:0], st[1:0], bk_[0], off[0]};
  endfunction

  // behavioural reference: one pass over the inputs in index order
  task automatic model();
    int stalls = 0;
    for (int b = 0; b < NB; b++) begin
      ek[b] = rv[b] ? 1 : (fv[b] ? 2 : 0);
      es[b] = 0; et[b] = 0; ew[b] = 0;
      efr[b] = rv[b] ? 0 : 1;
      for (int l = 0; l < LN; l++) begin elv[b][l] = 0; eid[b][l] = 0; etg[b][l] = 0; end
    end
    for (int i = 0; i < N; i++) begin
      int b = (ca[i] >> 1) & 1;
      int s = (ca[i] >> 2) & 3;
      int t = (ca[i] >> 4) & 15;
      int l = i % LN;
      er[i] = 0;
      if (!cv[i] || ek[b] == 1 || ek[b] == 2) continue;
      if ((!cw[i] || !wt) && mf[b]) begin stalls++; continue; end
      if (ek[b] == 3) begin
        if (es[b] == s && et[b] == t && ew[b] == int'(cw[i]) && elv[b][l] == 0) begin
          elv[b][l] = 1; eid[b][l] = i; etg[b][l] = ct[i]; er[i] = 1;
        end
      end else begin
        ek[b] = 3; es[b] = s; et[b] = t; ew[b] = cw[i];
        elv[b][l] = 1; eid[b][l] = i; etg[b][l] = ct[i]; er[i] = 1;
      end
    end
    estall = (estall + stalls) & 255;
  endtask

  task automatic step();
    model();
    #1;
    for (int i = 0; i < N; i++) chk("R8", $sformatf("core_ready[%0d]", i), crdy[i], er[i]);
    for (int b = 0; b < NB; b++) begin
      chk("R4", "fill_ready", fr[b], efr[b]);
      chk("R3", "replay_ready", rr[b], 1);
    end
    @(posedge clk); #1;
    for (int b = 0; b < NB; b++) begin
      chk("R10", "bq_valid", bv[b], ek[b] != 0);
      chk("R3", "bq_kind", bk[b], ek[b]);
      chk("R1", "bq_set", bs[b], es[b]);
      chk("R1", "bq_tag", bt[b], et[b]);
      chk("R6", "bq_write", bw[b], ew[b]);
      for (int l = 0; l < LN; l++) begin
        chk("R6", "lane_valid", blv[b][l], elv[b][l]);
        chk("R10", "lane_id", bid[b][l], eid[b][l]);
        chk("R10", "lane_tag", btg[b][l], etg[b][l]);
      end
    end
    chk("R7", "stall_cnt", sc, estall);
  endtask

  task automatic clr();
    cv = '0; cw = '0; ca = '0; ct = '0; rv = '0; fv = '0; mf = '0; wt = 1'b0; z_cv = '0;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: actual running, expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9", "bq_valid", bv, 0);
    chk("R9", "bq_lane_valid", blv, 0);
    chk("R9", "stall_cnt", sc, 0);
    rst_n = 1'b1;

    // R6 merge on two lanes
    cv = 4'b0011; ca[0] = mk(5, 1, 0, 0); ca[1] = mk(5, 1, 0, 1); ct[0] = 1; ct[1] = 2;
    step();
    // R6 lane clash: inputs 0 and 2 share lane 0
    cv = 4'b0101; ca[2] = mk(5, 1, 0, 1); ct[2] = 6;
    step();
    // R6 different set in same bank
    cv = 4'b0011; ca[1] = mk(5, 2, 0, 0);
    step();
    // R6 write flag mismatch
    ca[1] = mk(5, 1, 0, 0); cw = 4'b0010;
    step();
    // R3 / R5 replay and fill on bank 0, core to both banks
    cw = '0; rv = 2'b01; fv = 2'b01; ca[1] = mk(3, 2, 1, 0);
    step();
    // R4 fill alone
    rv = '0;
    step();
    // R7 full miss queue on bank 1
    clr(); mf = 2'b10; cv = 4'b0001; ca[0] = mk(7, 3, 1, 0);
    step();
    cw = 4'b0001; wt = 1'b1;
    step();
    wt = 1'b0;
    step();
    // R8 all inputs to bank 1, different lines
    clr();
    cv = 4'b1111;
    for (int i = 0; i < N; i++) begin ca[i] = mk(i, i, 1, 0); ct[i] = 3'(i + 1); end
    step();

    // random traffic
    for (int n = 0; n < 600; n++) begin
      cv = 4'($urandom); cw = 4'($urandom); wt = 1'($urandom);
      for (int i = 0; i < N; i++) begin
        ca[i] = mk($urandom % 2, $urandom % 4, $urandom % 2, $urandom % 2);
        ct[i] = 3'($urandom);
      end
      for (int b = 0; b < NB; b++) begin
        rv[b] = ($urandom % 4) == 0;
        fv[b] = ($urandom % 4) == 0;
        mf[b] = ($urandom % 4) == 0;
      end
      step();
    end

    // R2 zero-width bank field
    clr();
    z_cv = 4'b0001; ca[0] = 8'hFF;
    @(posedge clk); #1;
    chk("R2", "nobank valid", z_bv[0], 1);
    chk("R2", "nobank set", z_bs[0], 3);
    chk("R2", "nobank tag", z_bt[0], 31);
    ca[0] = 8'h02;
    @(posedge clk); #1;
    chk("R2", "nobank kind", z_bk[0], 3);
    chk("R2", "nobank tag zero", z_bt[0], 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule